// File: doc/BRIEF.md
# CMI Line Decoder and Word Deserializer

This block takes a recovered serial line that is sampled twice per bit, with one sample from each half of the symbol. A bit-rate clock enable marks each bit. In line-code mode the block decodes Coded Mark Inversion symbols into plain bits and watches for coding errors. In bypass mode it takes the first half-sample as the NRZ bit and passes it through unchanged. The resulting bits are packed, earliest first, into a parallel word of 2, 4 or 8 bits. A strobe marks each completed word and acts as the divided word clock.

Every register runs on the system clock. All state advances only on cycles where `bit_en` is high, so the strobe and the violation flag each last one bit period, meaning the interval up to the next enabled cycle. A synchronous active-high reset clears the whole block. The width code is sampled on every clock edge. A change of width restarts word assembly from a clean state.

Top module: `cmi_deser_top`

## Requirements
- R1: After synchronous reset, `par_data`, `par_valid`, `code_viol` and `cfg_invalid` are all zero.
- R2: With `nrz_mode` low, the half-symbol pair (`half_a`,`half_b`) decodes as follows: 01 gives bit 0, and both 00 and 11 give bit 1.
- R3: With `nrz_mode` low, either of two conditions is a violation. The first is a pair 10. The second is a mark (00 or 11) whose level equals the level of the previous mark since reset or since the last bypass bit. A violation drives `code_viol` high from the enabled edge that carries it until the next enabled edge, so it lasts exactly one bit period.
- R4: With `nrz_mode` high, the bit is `half_a`, `code_viol` is low after the enabled edge, and the mark-level history is forgotten.
- R5: `width_sel` 00 selects 2 bits, 10 selects 4 bits and 01 selects 8 bits. `par_valid` rises on the enabled edge that completes a word and falls on the next enabled edge, so there is one strobe per word.
- R6: In each delivered word, `par_data[0]` holds the earliest bit, and each higher index holds the next bit in arrival order.
- R7: Bits of `par_data` at or above the selected width are zero in every delivered word.
- R8: `width_sel` 11 operates as 2-bit mode. It sets `cfg_invalid` on the next clock edge, and the flag stays set until reset.
- R9: On the first edge at which a changed effective width is seen, the partial word, the bit count and any bit presented on that edge are discarded, and `par_valid` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate clock enable; one bit is consumed per high cycle |
| half_a | input | 1 | First half-symbol sample (the NRZ bit in bypass) |
| half_b | input | 1 | Second half-symbol sample |
| nrz_mode | input | 1 | 0 = CMI decode, 1 = NRZ bypass |
| width_sel | input | 2 | Word width code (00:2, 10:4, 01:8, 11:invalid) |
| par_data | output | 8 | Parallel word, bit 0 earliest |
| par_valid | output | 1 | Word strobe / divided word clock |
| code_viol | output | 1 | Code-violation flag, one bit period long |
| cfg_invalid | output | 1 | Sticky flag for invalid width code |

## Verification
Each bit is presented for exactly one enabled cycle. Its decoded value, its violation flag and any word it completes are all registered on that same rising edge. The bench therefore reads the outputs at the falling edge that follows, before the idle cycle that precedes the next bit. A width change is applied with `bit_en` low and given two cycles to take effect, because the flush and the invalid-code flag each appear one edge after the new code. Both the violation pulse and the word strobe must drop on the next enabled edge, and this is checked on the bit that follows each of them.

// File: rtl/cmi_deser_pkg.sv
package cmi_deser_pkg;

  typedef enum logic [1:0] {
    WID_2 = 2'd0,
    WID_4 = 2'd1,
    WID_8 = 2'd2
  } wid_e;

  // Map the external width code to an effective width; 11 falls back to 2 bits.
  function automatic wid_e wid_from_code(input logic [1:0] code);
    case (code)
      2'b10:   return WID_4;
      2'b01:   return WID_8;
      default: return WID_2;
    endcase
  endfunction

  // Index of the last bit of a word for a given width.
  function automatic int wid_last_idx(input wid_e w);
    case (w)
      WID_4:   return 3;
      WID_8:   return 7;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/cmi_symbol_dec.sv
module cmi_symbol_dec
  import cmi_deser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic nrz_mode,
  input  logic half_a,
  input  logic half_b,
  output logic dec_bit,
  output logic viol_q
);

  logic have_mark;
  logic mark_lvl;
  logic err;

  always_comb begin
    dec_bit = 1'b0;
    err     = 1'b0;
    if (nrz_mode) begin
      dec_bit = half_a;
    end else begin
      case ({half_a, half_b})
        2'b01: dec_bit = 1'b0;
        2'b10: begin
          dec_bit = 1'b0;
          err     = 1'b1;
        end
        default: begin
          dec_bit = 1'b1;
          err     = have_mark && (mark_lvl == half_a);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_mark <= 1'b0;
      mark_lvl  <= 1'b0;
      viol_q    <= 1'b0;
    end else if (bit_en) begin
      viol_q <= err;
      if (nrz_mode) begin
        have_mark <= 1'b0;
      end else if (half_a == half_b) begin
        have_mark <= 1'b1;
        mark_lvl  <= half_a;
      end
    end
  end

  AST_VIOL_LOW_NRZ: assert property (@(posedge clk) disable iff (rst)
    (bit_en && nrz_mode) |=> !viol_q); // R4

  AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(viol_q)); // R3

  AST_ALT_MARK_OK: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !nrz_mode && (half_a != half_b) && !half_a) |=> !viol_q); // R2

endmodule

// File: rtl/cmi_width_ctrl.sv
module cmi_width_ctrl
  import cmi_deser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] width_sel,
  output wid_e       wid_q,
  output logic       flush,
  output logic       cfg_bad
);

  wid_e wid_new;

  always_comb begin
    wid_new = wid_from_code(width_sel);
    flush   = (wid_new != wid_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wid_q   <= wid_new;
      cfg_bad <= 1'b0;
    end else begin
      wid_q <= wid_new;
      if (width_sel == 2'b11) cfg_bad <= 1'b1;
    end
  end

  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> cfg_bad); // R8

  AST_BAD_SETS: assert property (@(posedge clk) disable iff (rst)
    (width_sel == 2'b11) |=> cfg_bad); // R8

endmodule

// File: rtl/cmi_word_packer.sv
module cmi_word_packer
  import cmi_deser_pkg::*;
#(
  parameter int MAX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             flush,
  input  wid_e             wid_q,
  input  logic             bit_in,
  output logic [MAX_W-1:0] par_data,
  output logic             par_valid
);

  localparam int CNT_W = $clog2(MAX_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;
  logic [MAX_W-1:0] acc;
  logic [MAX_W-1:0] acc_nxt;
  logic [MAX_W-1:0] wmask;

  assign last_idx = CNT_W'(wid_last_idx(wid_q));

  for (genvar gi = 0; gi < MAX_W; gi++) begin : g_mask
    assign wmask[gi] = (int'(last_idx) >= gi);
  end

  always_comb begin
    acc_nxt      = acc;
    acc_nxt[cnt] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      acc       <= '0;
      par_data  <= '0;
      par_valid <= 1'b0;
    end else if (flush) begin
      cnt       <= '0;
      acc       <= '0;
      par_valid <= 1'b0;
    end else if (bit_en) begin
      if (cnt == last_idx) begin
        par_data  <= acc_nxt & wmask;
        par_valid <= 1'b1;
        cnt       <= '0;
        acc       <= '0;
      end else begin
        acc       <= acc_nxt;
        cnt       <= cnt + 1'b1;
        par_valid <= 1'b0;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_idx); // R5

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !flush) |=> $stable(par_valid)); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    par_valid |-> ((par_data & ~wmask) == '0)); // R7

  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !par_valid); // R9

endmodule

// File: rtl/cmi_deser_top.sv
module cmi_deser_top
  import cmi_deser_pkg::*;
#(
  parameter int MAX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             half_a,
  input  logic             half_b,
  input  logic             nrz_mode,
  input  logic [1:0]       width_sel,
  output logic [MAX_W-1:0] par_data,
  output logic             par_valid,
  output logic             code_viol,
  output logic             cfg_invalid
);

  logic dec_bit;
  logic flush;
  wid_e wid_q;

  cmi_symbol_dec u_dec (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .nrz_mode (nrz_mode),
    .half_a   (half_a),
    .half_b   (half_b),
    .dec_bit  (dec_bit),
    .viol_q   (code_viol)
  );

  cmi_width_ctrl u_wctl (
    .clk       (clk),
    .rst       (rst),
    .width_sel (width_sel),
    .wid_q     (wid_q),
    .flush     (flush),
    .cfg_bad   (cfg_invalid)
  );

  cmi_word_packer #(.MAX_W(MAX_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .flush     (flush),
    .wid_q     (wid_q),
    .bit_in    (dec_bit),
    .par_data  (par_data),
    .par_valid (par_valid)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!par_valid && !code_viol && !cfg_invalid)); // R1

endmodule

// File: tb/cmi_deser_top_tb_top.sv
module cmi_deser_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       half_a = 1'b0;
  logic       half_b = 1'b0;
  logic       nrz_mode = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic [7:0] par_data;
  logic       par_valid;
  logic       code_viol;
  logic       cfg_invalid;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  cmi_deser_top #(.MAX_W(8)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .half_a      (half_a),
    .half_b      (half_b),
    .nrz_mode    (nrz_mode),
    .width_sel   (width_sel),
    .par_data    (par_data),
    .par_valid   (par_valid),
    .code_viol   (code_viol),
    .cfg_invalid (cfg_invalid)
  );

  // Vector layout: {nrz, half_a, half_b, exp_viol, exp_valid, exp_data[7:0]}, width code 00.
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h02},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h03},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h01},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h03},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h02}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // One bit: one enabled cycle, outputs read at the next falling edge, then one idle cycle.
  task automatic send(input logic nrz, input logic a, input logic b);
    @(negedge clk);
    nrz_mode = nrz;
    half_a   = a;
    half_b   = b;
    bit_en   = 1'b1;
    @(negedge clk);
    bit_en   = 1'b0;
  endtask

  task automatic set_w(input logic [1:0] code);
    @(negedge clk);
    width_sel = code;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 data", 32'(par_data), 32'h0);
    chk("R1 valid", 32'(par_valid), 32'h0);
    chk("R1 viol", 32'(code_viol), 32'h0);
    chk("R1 cfg", 32'(cfg_invalid), 32'h0);

    // Table walk: CMI decode, violations, NRZ bypass (R4) in 2-bit words.
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][12], VEC[i][11], VEC[i][10]);
      chk(VEC[i][12] ? "R4 viol" : "R3 viol", 32'(code_viol), 32'(VEC[i][9]));
      chk("R5 valid", 32'(par_valid), 32'(VEC[i][8]));
      chk(VEC[i][12] ? "R4 data" : "R2 data", 32'(par_data), 32'(VEC[i][7:0]));
    end

    // R9: partial 2-bit word is dropped when switching to 4 bits.
    send(1'b1, 1'b1, 1'b0);
    set_w(2'b10);
    chk("R9 valid after flush", 32'(par_valid), 32'h0);
    send(1'b1, 1'b0, 1'b0);
    send(1'b1, 1'b1, 1'b0);
    chk("R9 no early word (2)", 32'(par_valid), 32'h0);
    send(1'b1, 1'b1, 1'b0);
    chk("R9 no early word (3)", 32'(par_valid), 32'h0);
    send(1'b1, 1'b0, 1'b0);
    chk("R9 valid 4-bit", 32'(par_valid), 32'h1);
    chk("R6 data 4-bit", 32'(par_data), 32'h06);

    // 8-bit words: bits 1,1,0,0,1,0,1,0 -> 0x53.
    set_w(2'b01);
    send(1'b1, 1'b1, 1'b0);
    send(1'b1, 1'b1, 1'b0);
    send(1'b1, 1'b0, 1'b0);
    send(1'b1, 1'b0, 1'b0);
    send(1'b1, 1'b1, 1'b0);
    send(1'b1, 1'b0, 1'b0);
    send(1'b1, 1'b1, 1'b0);
    chk("R5 no word at 7 of 8", 32'(par_valid), 32'h0);
    send(1'b1, 1'b0, 1'b0);
    chk("R5 valid 8-bit", 32'(par_valid), 32'h1);
    chk("R6 data 8-bit", 32'(par_data), 32'h53);
    send(1'b1, 1'b0, 1'b0);
    chk("R5 strobe drops", 32'(par_valid), 32'h0);

    // R8: invalid code behaves as 2-bit and latches the flag.
    chk("R8 flag clear before", 32'(cfg_invalid), 32'h0);
    set_w(2'b11);
    chk("R8 flag set", 32'(cfg_invalid), 32'h1);
    send(1'b1, 1'b0, 1'b0);
    send(1'b1, 1'b1, 1'b0);
    chk("R8 valid as 2-bit", 32'(par_valid), 32'h1);
    chk("R8 data as 2-bit", 32'(par_data), 32'h02);
    chk("R7 upper bits zero", 32'(par_data[7:2]), 32'h0);
    set_w(2'b00);
    chk("R8 flag sticky", 32'(cfg_invalid), 32'h1);

    // R3: same-polarity marks across a word boundary, then recovery.
    send(1'b0, 1'b1, 1'b1);
    send(1'b0, 1'b1, 1'b1);
    chk("R3 repeated mark", 32'(code_viol), 32'h1);
    @(negedge clk);
    chk("R3 held over idle cycle", 32'(code_viol), 32'h1);
    send(1'b0, 1'b0, 1'b0);
    chk("R3 one period only", 32'(code_viol), 32'h0);

    // R1: reset clears the sticky flag and the word.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cfg after reset", 32'(cfg_invalid), 32'h0);
    chk("R1 data after reset", 32'(par_data), 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule